// File: doc/BRIEF.md
# Input Overrange Detector

This block raises an overrange flag as early as the decimation chain allows. It has two independent ways to detect overrange. The first compares the magnitude of every first-stage decimation filter output against a programmable 16-bit threshold. This compare happens before any gain or offset correction is applied. The second watches a per-modulator-cycle strobe that reports when the input is beyond full scale. It trips as soon as that condition persists for more than four consecutive modulator samples.

The flag drives the overrange status bit directly. The flag also gates the data-valid qualifier that travels with the output samples, so that downstream logic cannot take data while overrange is set. The threshold register is written by a host through a simple write strobe and data word. The host bus itself lies outside this block.

Top module: `ovr_detect`

## Requirements
- R1: A synchronous reset clears the flag and the consecutive-sample counter, and loads the threshold with 0xCCCC. After reset, a sample whose magnitude has its upper 16 bits equal to 0xCCCC does not set the flag, and one with 0xCCCD does.
- R2: On each clock where `s1_valid` is high, the threshold hit is (upper 16 bits of |`s1_data`|) > threshold, using a strict greater-than. The flag on the next clock equals the threshold hit ORed with the trip condition.
- R3: `s1_data` is a two's-complement sample, and negative samples are compared by their magnitude. The most negative sample has a magnitude of 2^(SAMPLE_W-1), so its upper 16 bits are 0x8000.
- R4: A threshold write takes effect on the clock after `thr_wr_en`. A sample presented in the same cycle as the write is compared against the old threshold.
- R5: The counter counts clocks where `fs_strobe` and `fs_exceed` are both high. When it passes 4, which happens on the fifth consecutive over-full-scale strobe, the flag is set on the next clock edge. No first-stage sample is needed for this.
- R6: A clock with `fs_strobe` high and `fs_exceed` low resets the counter to zero. Therefore four exceeding strobes, then one clean strobe, then four more exceeding strobes never set the flag.
- R7: Once the counter has tripped, it saturates and keeps the flag set through below-threshold samples. The flag clears on the first below-threshold sample after a clean strobe.
- R8: On clocks with no sample and no trip, the flag holds its value.
- R9: `dvalid_out` equals `dvalid_in` AND NOT `ovr_flag`, in the same cycle.
- R10: `fs_exceed` is ignored on clocks where `fs_strobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | 16 | Threshold value to write |
| s1_valid | input | 1 | First-stage sample present |
| s1_data | input | SAMPLE_W | First-stage sample, two's complement |
| fs_strobe | input | 1 | One pulse per modulator cycle |
| fs_exceed | input | 1 | Input beyond full scale on this modulator cycle |
| dvalid_in | input | 1 | Data-valid of the outgoing sample |
| ovr_flag | output | 1 | Overrange status |
| dvalid_out | output | 1 | Data-valid after gating by overrange |

## Verification
`ovr_flag` is registered. It reflects a sample, a threshold write, or a strobe one clock edge after the cycle in which that input was presented. `dvalid_out` is combinational and is due in the same cycle. The bench drives each input on a falling edge and checks `dvalid_out` shortly afterwards, against the model's flag from before the edge. It then waits for one rising edge and checks `ovr_flag` at the following falling edge, against the model's state after that edge. Directed sequences cover the strict compare against the default threshold, the magnitude of the most negative sample, a write coinciding with a sample, the fourth and fifth strobes, a broken run of strobes, and a flag held by saturation.

// File: rtl/ovr_detect.sv
module ovr_detect #(
  parameter int SAMPLE_W = 24,
  parameter int THR_W = 16,
  parameter int TRIP_COUNT = 4,
  parameter logic [THR_W-1:0] THR_DEFAULT = 16'hCCCC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                thr_wr_en,
  input  logic [THR_W-1:0]    thr_wr_data,
  input  logic                s1_valid,
  input  logic [SAMPLE_W-1:0] s1_data,
  input  logic                fs_strobe,
  input  logic                fs_exceed,
  input  logic                dvalid_in,
  output logic                ovr_flag,
  output logic                dvalid_out
);
  localparam int CW = $clog2(TRIP_COUNT + 2);
  localparam logic [CW-1:0] CNT_SAT = CW'(TRIP_COUNT + 1);

  logic [THR_W-1:0]    thr;
  logic [CW-1:0]       cnt, cnt_nxt;
  logic [SAMPLE_W-1:0] mag;
  logic                hit, trip_nxt;

  assign mag = s1_data[SAMPLE_W-1] ? (~s1_data + 1'b1) : s1_data;
  assign hit = mag[SAMPLE_W-1 -: THR_W] > thr;

  always_comb begin
    cnt_nxt = cnt;
    if (fs_strobe)
      cnt_nxt = !fs_exceed ? '0 : (cnt == CNT_SAT) ? cnt : cnt + 1'b1;
  end

  assign trip_nxt = cnt_nxt == CNT_SAT;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr      <= THR_DEFAULT;
      cnt      <= '0;
      ovr_flag <= 1'b0;
    end else begin
      if (thr_wr_en) thr <= thr_wr_data;
      cnt <= cnt_nxt;
      if (s1_valid)      ovr_flag <= hit | trip_nxt;
      else if (trip_nxt) ovr_flag <= 1'b1;
    end
  end

  assign dvalid_out = dvalid_in & ~ovr_flag;
endmodule

// File: rtl/ovr_detect_chk.sv
module ovr_detect_chk #(
  parameter int THR_W = 16,
  parameter int CW = 3,
  parameter int TRIP_COUNT = 4,
  parameter logic [THR_W-1:0] THR_DEFAULT = 16'hCCCC
) (
  input logic             clk,
  input logic             rst,
  input logic             s1_valid,
  input logic             fs_strobe,
  input logic             fs_exceed,
  input logic             dvalid_out,
  input logic             ovr_flag,
  input logic [THR_W-1:0] thr,
  input logic [CW-1:0]    cnt
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (thr == THR_DEFAULT && cnt == '0 && !ovr_flag));

  assert_trip_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (fs_strobe && fs_exceed && cnt >= CW'(TRIP_COUNT)) |=> ovr_flag);

  assert_clean_strobe_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (fs_strobe && !fs_exceed) |=> cnt == '0);

  assert_count_saturates_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(TRIP_COUNT + 1));

  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!s1_valid && !(fs_strobe && fs_exceed)) |=> $stable(ovr_flag));

  assert_dvalid_gated_R9: assert property (@(posedge clk) disable iff (rst)
    ovr_flag |-> !dvalid_out);

  assert_idle_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !fs_strobe |=> $stable(cnt));
endmodule

bind ovr_detect ovr_detect_chk #(
  .THR_W(THR_W), .CW(CW), .TRIP_COUNT(TRIP_COUNT), .THR_DEFAULT(THR_DEFAULT)
) chk_i (
  .clk(clk), .rst(rst), .s1_valid(s1_valid), .fs_strobe(fs_strobe),
  .fs_exceed(fs_exceed), .dvalid_out(dvalid_out), .ovr_flag(ovr_flag),
  .thr(thr), .cnt(cnt)
);

// File: tb/ovr_detect_tb_top.sv
`timescale 1ns/1ps
module ovr_detect_tb_top;
  localparam int SW = 24;
  localparam int TRIP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic thr_wr_en = 0, s1_valid = 0, fs_strobe = 0, fs_exceed = 0, dvalid_in = 0;
  logic [15:0] thr_wr_data = '0;
  logic [SW-1:0] s1_data = '0;
  logic ovr_flag, dvalid_out;

  int n_vec = 0, n_bad = 0;
  bit m_flag = 0;
  int m_cnt = 0;
  logic [15:0] m_thr = 16'hCCCC;

  always #2 clk = ~clk;

  ovr_detect dut_i (
    .clk(clk), .rst(rst), .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
    .s1_valid(s1_valid), .s1_data(s1_data), .fs_strobe(fs_strobe),
    .fs_exceed(fs_exceed), .dvalid_in(dvalid_in), .ovr_flag(ovr_flag),
    .dvalid_out(dvalid_out)
  );

  function automatic bit exp_hit(logic [SW-1:0] d, logic [15:0] t);
    logic [SW-1:0] m;
    m = d[SW-1] ? (~d + 1'b1) : d;
    return m[SW-1 -: 16] > t;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit wr, logic [15:0] wd, bit sv, logic [SW-1:0] sd,
                      bit fst, bit fex, bit dv);
    bit tripn, h;
    thr_wr_en = wr; thr_wr_data = wd; s1_valid = sv; s1_data = sd;
    fs_strobe = fst; fs_exceed = fex; dvalid_in = dv;
    #0.5;
    check("R9 dvalid gate", dvalid_out, dv & ~m_flag);
    h = exp_hit(sd, m_thr);
    if (fst) m_cnt = fex ? ((m_cnt == TRIP + 1) ? m_cnt : m_cnt + 1) : 0;
    tripn = m_cnt > TRIP;
    if (sv) m_flag = h | tripn;
    else if (tripn) m_flag = 1'b1;
    if (wr) m_thr = wd;
    @(posedge clk); @(negedge clk);
    check(tag, ovr_flag, m_flag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, '0, 0, '0, 0, 0, 1);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    dvalid_in = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 flag after reset", ovr_flag, 1'b0);
    check("R9 dvalid after reset", dvalid_out, 1'b1);
    step("R1 default thr equal", 0, '0, 1, {16'hCCCC, 8'hFF}, 0, 0, 1);
    step("R1 default thr above", 0, '0, 1, {16'hCCCD, 8'h00}, 0, 0, 1);
    idle("R8 hold set", 2);
    step("R2 below clears", 0, '0, 1, 24'h000100, 0, 0, 1);
    // R3 magnitude of negatives
    step("R3 negative above", 0, '0, 1, -{16'hCCCD, 8'h00}, 0, 0, 1);
    step("R3 most negative", 0, '0, 1, 24'h800000, 0, 0, 1);
    // R4 write timing
    step("R4 same-cycle old thr", 1, 16'h1000, 1, {16'h2000, 8'h0}, 0, 0, 1);
    step("R4 new thr applies", 0, '0, 1, {16'h2000, 8'h0}, 0, 0, 1);
    step("R4 restore", 1, 16'hCCCC, 1, 24'h0, 0, 0, 1);
    // R5 trip on fifth strobe
    for (int i = 0; i < 4; i++) step("R5 four strobes no trip", 0, '0, 0, '0, 1, 1, 1);
    step("R5 fifth strobe trips", 0, '0, 0, '0, 1, 1, 1);
    // R7 saturation keeps flag through small samples
    step("R7 saturated small sample", 0, '0, 1, 24'h10, 1, 1, 1);
    step("R7 clean strobe holds", 0, '0, 0, '0, 1, 0, 1);
    step("R7 sample after clean clears", 0, '0, 1, 24'h10, 0, 0, 1);
    // R6 broken run, R10 ignored without strobe
    for (int i = 0; i < 4; i++) step("R6 run a", 0, '0, 0, '0, 1, 1, 1);
    step("R6 break", 0, '0, 0, '0, 1, 0, 1);
    for (int i = 0; i < 4; i++) step("R6 run b", 0, '0, 0, '0, 1, 1, 1);
    for (int i = 0; i < 3; i++) step("R10 exceed without strobe", 0, '0, 0, '0, 0, 1, 1);
    step("R6 clean", 0, '0, 0, '0, 1, 0, 1);
    // random mix
    begin
      bit burst = 0;
      for (int i = 0; i < 4000; i++) begin
        bit wr, sv, fst, fex;
        logic [15:0] wd, up;
        logic [SW-1:0] sd;
        if ($urandom_range(0, 15) == 0) burst = ~burst;
        wr = $urandom_range(0, 49) == 0;
        wd = $urandom_range(0, 3) == 0 ? 16'(16'hCCCC) : 16'($urandom);
        sv = $urandom_range(0, 2) == 0;
        up = m_thr + 16'($urandom_range(0, 4)) - 16'd2;
        sd = $urandom_range(0, 1) ? {up, 8'($urandom)} : SW'($urandom);
        if ($urandom_range(0, 1)) sd = ~sd + 1'b1;
        fst = $urandom_range(0, 1);
        fex = burst ? ($urandom_range(0, 19) != 0) : ($urandom_range(0, 3) == 0);
        step("R2 random", wr, wd, sv, sd, fst, fex, 1'($urandom));
      end
    end
    // R1 reset mid-run
    rst = 1; @(negedge clk); rst = 0;
    m_flag = 0; m_cnt = 0; m_thr = 16'hCCCC;
    check("R1 flag after re-reset", ovr_flag, 1'b0);
    step("R1 thr reloaded", 0, '0, 1, {16'hCCCD, 8'h0}, 0, 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule